// File: doc/BRIEF.md
# Sequential 32-by-16 Integer Divider

This block divides a 32-bit dividend by a 16-bit divisor, one quotient bit per clock, using a restoring shift-and-subtract loop. A single mode input picks between unsigned division and two's complement signed division. The unit accepts a request when it is idle and `start` is high. It reports completion with a one-cycle `done` pulse. On success it writes a packed word that holds the remainder in the upper half and the quotient in the lower half, and it pulses `wr_en` in the same cycle.

The condition flags N, Z, V and C are registered outputs that a surrounding sequencer can copy into its status word. A zero divisor does not produce a result. Instead it raises a one-cycle `div_zero` strobe and sets a fixed flag pattern. A quotient that cannot be held in 16 bits sets V and leaves the result register alone. When the magnitude of the upper half of the dividend already reaches the magnitude of the divisor, the quotient cannot fit. The unit detects this before iterating and finishes early.

Top module: `div32x16_unit`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) with a quotient of at most 65535, `result` becomes {remainder[15:0], quotient[15:0]} and `wr_en` pulses high together with `done`.
- R2: In signed mode (`signed_mode`=1), the divisor is treated as a sign-extended 16-bit value. The quotient truncates toward zero, and a nonzero remainder carries the sign of the dividend. The packing is the same as in R1.
- R3: On a successful division, V is cleared, Z is set exactly when the 16-bit quotient is zero, and N equals bit 15 of the quotient.
- R4: Every completed division leaves C cleared, whatever its outcome.
- R5: A zero divisor pulses `div_zero` with `done` and sets N=0, Z=1, V=0. `wr_en` stays low and `result` keeps its previous value.
- R6: In unsigned mode, a quotient above 65535 sets V. `wr_en` stays low, `result` is unchanged, and N and Z keep their previous values.
- R7: In signed mode, a quotient outside -32768..32767 sets V with the same hold behaviour as R6. This includes 0x80000000 divided by -1.
- R8: Counting the clock edge that accepts `start` as edge 1, `done` is visible after edge 2 for a zero divisor or when the quotient magnitude is at least 65536. In all other cases it is visible after edge 19. `busy` is high from acceptance until `done`, and `done` lasts exactly one cycle.
- R9: `start` is ignored while `busy` is high. It changes neither the operation in flight nor its result, and it does not cause a second completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division (accepted only when idle) |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| dividend | input | 32 | Dividend operand |
| divisor | input | 16 | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed {remainder, quotient}, updated on success only |
| wr_en | output | 1 | Result was written this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| div_zero | output | 1 | Divide-by-zero exception strobe |

## Verification
Fully random operands mostly reach the early-overflow path. They show that overflow detection and result hold are correct, but they say little about the quotient. Random dividends shifted right by a random amount mostly give quotients that fit. These operands test the iteration loop, the remainder packing and the N and Z flags over the full range. Signed cases cover each combination of operand signs. They distinguish truncation toward zero and the remainder sign from a plain magnitude divide. Directed corners cover the following:
- 0x80000000 / -1
- divide by 1
- quotients of exactly 65535, 32767 and -32768, plus one beyond each
- zero divisors in both modes
- a second start raised mid-operation

These corners separate the signed limit test, the early exit and the busy lockout.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int DIV_DVD_W = 32;
    localparam int DIV_DSR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIN   = 2'd3
    } div_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } div_flags_t;

    // Flag image for a zero divisor
    function automatic div_flags_t zero_div_flags();
        div_flags_t f;
        f.n = 1'b0;
        f.z = 1'b1;
        f.v = 1'b0;
        f.c = 1'b0;
        return f;
    endfunction

    // Flag image for an overflow: N and Z carried over from the old value
    function automatic div_flags_t ovf_flags(input div_flags_t prev);
        div_flags_t f;
        f.n = prev.n;
        f.z = prev.z;
        f.v = 1'b1;
        f.c = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
#(
    parameter int DW = DIV_DVD_W,
    parameter int SW = DIV_DSR_W
) (
    input  logic          sgn,
    input  logic [DW-1:0] dvd,
    input  logic [SW-1:0] dsr,
    output logic [DW-1:0] dvd_mag,
    output logic [SW-1:0] dsr_mag,
    output logic          dvd_neg,
    output logic          quo_neg,
    output logic          dsr_zero,
    output logic          early_ovf
);
    localparam int QW = DW - SW;

    logic dsr_neg;

    always_comb begin
        dvd_neg  = sgn & dvd[DW-1];
        dsr_neg  = sgn & dsr[SW-1];
        dvd_mag  = dvd_neg ? (~dvd + DW'(1)) : dvd;
        dsr_mag  = dsr_neg ? (~dsr + SW'(1)) : dsr;
        quo_neg  = dvd_neg ^ dsr_neg;
        dsr_zero = (dsr == '0);
        // Upper part of the magnitude already at or above the divisor:
        // the quotient magnitude is 2**QW or more.
        early_ovf = (dvd_mag[DW-1:QW] >= dsr_mag);
    end

endmodule

// File: rtl/div_restore_core.sv
module div_restore_core
    import div_pkg::*;
#(
    parameter int DW = DIV_DVD_W,
    parameter int SW = DIV_DSR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] dvd_mag,
    input  logic [SW-1:0] dsr_mag,
    output logic [DW-SW-1:0] quo_mag,
    output logic [SW-1:0] rem_mag
);
    localparam int QW = DW - SW;

    logic [SW-1:0] part_q;
    logic [QW-1:0] shift_q;
    logic [SW-1:0] dsr_q;
    logic [SW:0]   trial;
    logic [SW:0]   diff;
    logic          fits;

    always_comb begin
        trial = {part_q, shift_q[QW-1]};
        diff  = trial - {1'b0, dsr_q};
        fits  = (trial >= {1'b0, dsr_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            shift_q <= '0;
            dsr_q   <= '0;
        end else if (load) begin
            part_q  <= dvd_mag[DW-1:QW];
            shift_q <= dvd_mag[QW-1:0];
            dsr_q   <= dsr_mag;
        end else if (step) begin
            part_q  <= fits ? diff[SW-1:0] : trial[SW-1:0];
            shift_q <= {shift_q[QW-2:0], fits};
        end
    end

    assign quo_mag = shift_q;
    assign rem_mag = part_q;

endmodule

// File: rtl/div_result_pack.sv
module div_result_pack
    import div_pkg::*;
#(
    parameter int DW = DIV_DVD_W,
    parameter int SW = DIV_DSR_W
) (
    input  logic             sgn,
    input  logic             quo_neg,
    input  logic             rem_neg,
    input  logic [DW-SW-1:0] quo_mag,
    input  logic [SW-1:0]    rem_mag,
    output logic [DW-1:0]    packed_word,
    output logic             late_ovf,
    output logic             res_n,
    output logic             res_z
);
    localparam int QW = DW - SW;
    localparam logic [QW-1:0] NEG_LIMIT = {1'b1, {(QW-1){1'b0}}};

    logic [QW-1:0] quo_s;
    logic [SW-1:0] rem_s;

    always_comb begin
        quo_s = quo_neg ? (~quo_mag + QW'(1)) : quo_mag;
        rem_s = rem_neg ? (~rem_mag + SW'(1)) : rem_mag;
        if (sgn) begin
            late_ovf = quo_neg ? (quo_mag > NEG_LIMIT) : quo_mag[QW-1];
        end else begin
            late_ovf = 1'b0;
        end
        packed_word = {rem_s, quo_s};
        res_n       = quo_s[QW-1];
        res_z       = (quo_s == '0);
    end

endmodule

// File: rtl/div32x16_unit.sv
module div32x16_unit
    import div_pkg::*;
#(
    parameter int DW = DIV_DVD_W,
    parameter int SW = DIV_DSR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          signed_mode,
    input  logic [DW-1:0] dividend,
    input  logic [SW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          wr_en,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c,
    output logic          div_zero
);
    localparam int QW    = DW - SW;
    localparam int CNT_W = (QW > 1) ? $clog2(QW) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(QW - 1);

    div_state_e state_q;
    logic [DW-1:0] op_dvd_q;
    logic [SW-1:0] op_dsr_q;
    logic          op_sgn_q;
    logic [CNT_W-1:0] cnt_q;

    logic [DW-1:0] dvd_mag;
    logic [SW-1:0] dsr_mag;
    logic          dvd_neg;
    logic          quo_neg;
    logic          dsr_zero;
    logic          early_ovf;

    logic [QW-1:0] quo_mag;
    logic [SW-1:0] rem_mag;
    logic [DW-1:0] packed_word;
    logic          late_ovf;
    logic          res_n;
    logic          res_z;

    logic          core_load;
    logic          core_step;

    div_flags_t flags_q;
    logic [DW-1:0] result_q;
    logic done_q;
    logic wr_q;
    logic dz_q;

    div_operand_prep #(.DW(DW), .SW(SW)) u_prep (
        .sgn      (op_sgn_q),
        .dvd      (op_dvd_q),
        .dsr      (op_dsr_q),
        .dvd_mag  (dvd_mag),
        .dsr_mag  (dsr_mag),
        .dvd_neg  (dvd_neg),
        .quo_neg  (quo_neg),
        .dsr_zero (dsr_zero),
        .early_ovf(early_ovf)
    );

    assign core_load = (state_q == ST_CHECK) && !dsr_zero && !early_ovf;
    assign core_step = (state_q == ST_RUN);

    div_restore_core #(.DW(DW), .SW(SW)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load   (core_load),
        .step   (core_step),
        .dvd_mag(dvd_mag),
        .dsr_mag(dsr_mag),
        .quo_mag(quo_mag),
        .rem_mag(rem_mag)
    );

    div_result_pack #(.DW(DW), .SW(SW)) u_pack (
        .sgn        (op_sgn_q),
        .quo_neg    (quo_neg),
        .rem_neg    (dvd_neg),
        .quo_mag    (quo_mag),
        .rem_mag    (rem_mag),
        .packed_word(packed_word),
        .late_ovf   (late_ovf),
        .res_n      (res_n),
        .res_z      (res_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            op_dvd_q <= '0;
            op_dsr_q <= '0;
            op_sgn_q <= 1'b0;
            cnt_q    <= '0;
            flags_q  <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            wr_q     <= 1'b0;
            dz_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            dz_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_dvd_q <= dividend;
                        op_dsr_q <= divisor;
                        op_sgn_q <= signed_mode;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (dsr_zero) begin
                        flags_q <= zero_div_flags();
                        dz_q    <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (early_ovf) begin
                        flags_q <= ovf_flags(flags_q);
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    if (late_ovf) begin
                        flags_q <= ovf_flags(flags_q);
                    end else begin
                        flags_q.n <= res_n;
                        flags_q.z <= res_z;
                        flags_q.v <= 1'b0;
                        flags_q.c <= 1'b0;
                        result_q  <= packed_word;
                        wr_q      <= 1'b1;
                    end
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign wr_en    = wr_q;
    assign div_zero = dz_q;
    assign result   = result_q;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_v   = flags_q.v;
    assign flag_c   = flags_q.c;

endmodule

// File: rtl/div32x16_checker.sv
module div32x16_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result,
    input logic          wr_en,
    input logic          flag_n,
    input logic          flag_z,
    input logic          flag_v,
    input logic          div_zero
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_ZERO_DIV_FLAGS: assert property (@(posedge clk) disable iff (rst)
        div_zero |-> (done && flag_z && !flag_n && !flag_v && !wr_en)); // R5

    AST_WRITE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (done && !flag_v && !div_zero)); // R3

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> $stable(result)); // R6

    AST_OVF_KEEPS_NZ: assert property (@(posedge clk) disable iff (rst)
        (done && flag_v) |-> ($stable(flag_n) && $stable(flag_z) && !wr_en)); // R7

endmodule

bind div32x16_unit div32x16_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .wr_en   (wr_en),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .div_zero(div_zero)
);

// File: tb/div32x16_unit_tb.sv
`timescale 1ns/1ps
module div32x16_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, wr_en, flag_n, flag_z, flag_v, flag_c, div_zero;
    logic [31:0] result;

    int total = 0;
    int bad = 0;

    logic [31:0] m_res = '0;
    logic        m_n = 1'b0;
    logic        m_z = 1'b0;

    always #2 clk = ~clk;

    div32x16_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .div_zero(div_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] dd, input logic [15:0] ds, input bit sm,
                          input string req, input bit poke_busy);
        longint a, b, q, r, qa;
        bit dz, ovf, early;
        logic [31:0] exp_res;
        int n;
        bit seen;
        a = sm ? longint'($signed(dd)) : longint'(dd);
        b = sm ? longint'($signed(ds)) : longint'(ds);
        dz = (b == 0);
        ovf = 1'b0; early = 1'b0; q = 0; r = 0;
        if (!dz) begin
            q = a / b;
            r = a % b;
            qa = (q < 0) ? -q : q;
            early = (qa >= 65536);
            ovf = sm ? (q > 32767 || q < -32768) : (q > 65535);
        end
        exp_res = {r[15:0], q[15:0]};

        @(negedge clk);
        dividend = dd; divisor = ds; signed_mode = sm; start = 1'b1;
        n = 0; seen = 1'b0;
        while (n < 40 && !seen) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (poke_busy && n == 5) begin
                // R9: second request with other operands while busy
                dividend = ~dd; divisor = 16'h0003; signed_mode = ~sm; start = 1'b1;
            end
            if (done) seen = 1'b1;
        end
        start = 1'b0;
        check(seen, "R8", "done seen", 64'(seen), 64'd1);
        check(n == ((dz || early) ? 2 : 19), "R8", "latency", 64'(n), (dz || early) ? 64'd2 : 64'd19);
        check(flag_c == 1'b0, "R4", "carry", 64'(flag_c), 64'd0);
        if (dz) begin
            check(div_zero && !wr_en, "R5", "strobe/we", {div_zero, wr_en}, 2'b10);
            check({flag_n, flag_z, flag_v} == 3'b010, "R5", "flags nzv", {flag_n, flag_z, flag_v}, 3'b010);
            check(result == m_res, "R5", "result held", result, m_res);
            m_n = 1'b0; m_z = 1'b1;
        end else if (ovf) begin
            check(flag_v && !wr_en && !div_zero, sm ? "R7" : "R6", "v/we", {flag_v, wr_en, div_zero}, 3'b100);
            check(flag_n == m_n && flag_z == m_z, sm ? "R7" : "R6", "nz kept", {flag_n, flag_z}, {m_n, m_z});
            check(result == m_res, sm ? "R7" : "R6", "result held", result, m_res);
        end else begin
            check(wr_en && !div_zero, "R1", "we", {wr_en, div_zero}, 2'b10);
            check(result == exp_res, sm ? "R2" : "R1", req, result, exp_res);
            check(!flag_v && flag_n == exp_res[15] && flag_z == (exp_res[15:0] == 0),
                  "R3", "flags nzv", {flag_n, flag_z, flag_v},
                  {exp_res[15], exp_res[15:0] == 16'h0, 1'b0});
            m_res = exp_res; m_n = exp_res[15]; m_z = (exp_res[15:0] == 0);
        end
        @(negedge clk);
        check(!done, "R8", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C3B4A));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, wr_en, div_zero} == 4'b0, "R8", "reset ctl", {busy, done, wr_en, div_zero}, 4'b0);
        check(result == 0 && {flag_n, flag_z, flag_v, flag_c} == 4'b0, "R4", "reset state",
              {result, flag_n, flag_z, flag_v, flag_c}, 64'd0);

        run_op(32'd1000, 16'd7, 1'b0, "R1 basic", 1'b0);
        run_op(32'h0000FFFF, 16'd1, 1'b0, "R1 div1", 1'b0);
        run_op(32'h0001FFFE, 16'd2, 1'b0, "R1 max quotient", 1'b0);
        run_op(32'h00010000, 16'd1, 1'b0, "R6 just over", 1'b0);
        run_op(32'h00020000, 16'd2, 1'b0, "R6 late edge", 1'b0);
        run_op(32'd5, 16'd9, 1'b0, "R3 zero quotient", 1'b0);
        run_op(32'h12345678, 16'h0000, 1'b0, "R5 unsigned", 1'b0);
        run_op(32'h80000000, 16'hFFFF, 1'b1, "R7 min by -1", 1'b0);
        run_op(-32'sd7, 16'd2, 1'b1, "R2 neg rem", 1'b0);
        run_op(32'd7, 16'hFFFE, 1'b1, "R2 neg divisor", 1'b0);
        run_op(-32'sd7, 16'hFFFE, 1'b1, "R2 both neg", 1'b0);
        run_op(32'h00007FFF, 16'd1, 1'b1, "R2 max pos", 1'b0);
        run_op(32'h00008000, 16'd1, 1'b1, "R7 pos over", 1'b0);
        run_op(32'hFFFF8000, 16'd1, 1'b1, "R2 min neg", 1'b0);
        run_op(32'hFFFF7FFF, 16'd1, 1'b1, "R7 neg over", 1'b0);
        run_op(32'h00000000, 16'h0000, 1'b1, "R5 signed", 1'b0);
        run_op(32'd99991, 16'd13, 1'b0, "R9 busy poke", 1'b1);
        repeat (25) begin
            @(negedge clk);
            check(!done && !busy, "R9", "no extra op", {done, busy}, 2'b00);
        end

        for (int i = 0; i < 400; i++) begin
            logic [31:0] dd;
            logic [15:0] ds;
            bit sm;
            dd = $urandom();
            ds = 16'($urandom());
            sm = 1'($urandom());
            case ($urandom() % 3)
                0: ;
                1: dd = dd >> ($urandom() % 24);
                default: dd = 32'($signed(16'(dd)));
            endcase
            if ($urandom() % 32 == 0) ds = 16'h0;
            run_op(dd, ds, sm, sm ? "R2 random" : "R1 random", 1'b0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule